// File: doc/BRIEF.md
# Processor Window Mapper for Video Memory

This block lets a processor with a 64KB address space reach video memory directly through its memory bus. A 16KB window is placed in one of the four 16KB processor pages. Within that window, plain loads and stores reach one bank of video memory. The processor sets the block up with two I/O writes. One write selects the page and can switch the window off. The other write selects the bank. Neither setting needs a read-modify step.

Each processor access that lands in the window is turned into one request on a simple request/acknowledge port. Banks 0 to 31 address a 512KB normal region. One further bank, numbered 32, is steered to a separate small region that holds the sprite attribute and palette storage. Any higher bank number leads nowhere. While a request is outstanding, the processor is held by a wait output. Read data comes back on a registered output.

Top module: `vram_window_mapper`

## Requirements
- R1: After reset the window is off, so no access is claimed, and the bank register holds 0.
- R2: An I/O write with `io_sel`=0 loads the page field from bits [1:0] and the off flag from bit 7. A memory access is claimed only when the window is on and address bits [15:14] equal the page field.
- R3: While the off flag is set, no access is claimed, `cpu_wait` stays low and no request is issued.
- R4: An I/O write with `io_sel`=1 replaces the whole 8-bit bank register in one step. For banks 0 to 31 a claimed access requests address bank×16384 + (address bits [13:0]), with `vram_spec`=0.
- R5: For bank 32 a claimed access requests the special region with `vram_spec`=1, and the address is the 14-bit offset, zero-extended.
- R6: For banks 33 to 255 a claimed access issues no request. A read returns 0xFF and a write changes nothing.
- R7: `cpu_wait` is high from the first cycle of a claimed, mapped access until the cycle after `vram_ack`. The request and its address stay steady until they are acknowledged.
- R8: A claimed read returns the `vram_rdata` value that was present with `vram_ack` on `mem_rdata` once `cpu_wait` falls.
- R9: Each claimed, mapped access issues exactly one request. For a write, `vram_we`=1 and `vram_wdata` carries the processor data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe, one cycle |
| io_sel | input | 1 | 0 = page/off register, 1 = bank register |
| io_data | input | 8 | I/O write data |
| mem_rd | input | 1 | Processor memory read, held until `cpu_wait` falls |
| mem_wr | input | 1 | Processor memory write, held until `cpu_wait` falls |
| mem_addr | input | 16 | Processor memory address |
| mem_wdata | input | 8 | Processor write data |
| mem_rdata | output | 8 | Read data returned to the processor |
| mem_claim | output | 1 | Access falls in the active window |
| cpu_wait | output | 1 | Hold the processor |
| vram_req | output | 1 | Request, held until acknowledged |
| vram_we | output | 1 | Request is a write |
| vram_spec | output | 1 | Request targets the special region |
| vram_addr | output | 19 | Request address |
| vram_wdata | output | 8 | Request write data |
| vram_ack | input | 1 | Request done, one cycle |
| vram_rdata | input | 8 | Read data valid with `vram_ack` |

## Verification
The bench builds the block with its default parameters: a 16KB window, 32 normal banks and an 8-bit bank register. With these values the whole bank range can be covered. That range includes the last normal bank at the top offset (address 0x7FFFF), the special bank 32, and the unmapped values 33 and 255. All four page positions can also be reached. Responder latency is randomised from 0 to 2 cycles, which tests how long the wait output is held.

// File: rtl/vwm_pkg.sv
package vwm_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_BUSY = 2'd1,
    SQ_DONE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/vwm_regs.sv
module vwm_regs #(
  parameter int DW     = 8,
  parameter int PAGE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic              io_sel,
  input  logic [DW-1:0]     io_data,
  output logic [PAGE_W-1:0] page_q,
  output logic              off_q,
  output logic [DW-1:0]     bank_q
);
  localparam int OFF_BIT = DW - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      off_q  <= 1'b1;
      bank_q <= '0;
    end else if (io_wr) begin
      if (!io_sel) begin
        page_q <= io_data[PAGE_W-1:0];
        off_q  <= io_data[OFF_BIT];
      end else begin
        bank_q <= io_data;
      end
    end
  end
endmodule

// File: rtl/vwm_decode.sv
module vwm_decode #(
  parameter int DW      = 8,
  parameter int CPU_AW  = 16,
  parameter int WIN_AW  = 14,
  parameter int N_BANKS = 32,
  parameter int SEL_W   = $clog2(N_BANKS),
  parameter int VRAM_AW = WIN_AW + SEL_W
) (
  input  logic [CPU_AW-1:0]        mem_addr,
  input  logic                     mem_rd,
  input  logic                     mem_wr,
  input  logic [CPU_AW-WIN_AW-1:0] page_q,
  input  logic                     off_q,
  input  logic [DW-1:0]            bank_q,
  output logic                     hit,
  output logic                     tgt_void,
  output logic                     tgt_spec,
  output logic [VRAM_AW-1:0]       tgt_addr
);
  localparam logic [DW-1:0] SPEC_BANK = DW'(N_BANKS);

  logic [WIN_AW-1:0] offset;

  always_comb begin
    offset   = mem_addr[WIN_AW-1:0];
    hit      = !off_q && (mem_rd || mem_wr) &&
               (mem_addr[CPU_AW-1:WIN_AW] == page_q);
    tgt_spec = (bank_q == SPEC_BANK);
    tgt_void = (bank_q > SPEC_BANK);
    if (bank_q < SPEC_BANK) tgt_addr = {bank_q[SEL_W-1:0], offset};
    else                    tgt_addr = VRAM_AW'(offset);
  end
endmodule

// File: rtl/vwm_seq.sv
module vwm_seq
  import vwm_pkg::*;
#(
  parameter int DW      = 8,
  parameter int VRAM_AW = 19
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mem_rd,
  input  logic               mem_wr,
  input  logic [DW-1:0]      mem_wdata,
  input  logic               hit,
  input  logic               tgt_void,
  input  logic               tgt_spec,
  input  logic [VRAM_AW-1:0] tgt_addr,
  input  logic               vram_ack,
  input  logic [DW-1:0]      vram_rdata,
  output logic               cpu_wait,
  output logic [DW-1:0]      mem_rdata,
  output logic               vram_req,
  output logic               vram_we,
  output logic               vram_spec,
  output logic [VRAM_AW-1:0] vram_addr,
  output logic [DW-1:0]      vram_wdata
);
  seq_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_IDLE;
      vram_req   <= 1'b0;
      vram_we    <= 1'b0;
      vram_spec  <= 1'b0;
      vram_addr  <= '0;
      vram_wdata <= '0;
      mem_rdata  <= '1;
    end else begin
      case (st)
        SQ_IDLE: if (hit) begin
          if (tgt_void) begin
            mem_rdata <= '1;
            st        <= SQ_DONE;
          end else begin
            vram_req   <= 1'b1;
            vram_we    <= mem_wr;
            vram_spec  <= tgt_spec;
            vram_addr  <= tgt_addr;
            vram_wdata <= mem_wdata;
            st         <= SQ_BUSY;
          end
        end
        SQ_BUSY: if (vram_ack) begin
          vram_req <= 1'b0;
          if (!vram_we) mem_rdata <= vram_rdata;
          st <= SQ_DONE;
        end
        SQ_DONE: if (!mem_rd && !mem_wr) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign cpu_wait = hit && (st != SQ_DONE);
endmodule

// File: rtl/vram_window_mapper.sv
module vram_window_mapper #(
  parameter int DW      = 8,
  parameter int CPU_AW  = 16,
  parameter int WIN_AW  = 14,
  parameter int N_BANKS = 32,
  parameter int SEL_W   = $clog2(N_BANKS),
  parameter int VRAM_AW = WIN_AW + SEL_W,
  parameter int PAGE_W  = CPU_AW - WIN_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               io_wr,
  input  logic               io_sel,
  input  logic [DW-1:0]      io_data,
  input  logic               mem_rd,
  input  logic               mem_wr,
  input  logic [CPU_AW-1:0]  mem_addr,
  input  logic [DW-1:0]      mem_wdata,
  output logic [DW-1:0]      mem_rdata,
  output logic               mem_claim,
  output logic               cpu_wait,
  output logic               vram_req,
  output logic               vram_we,
  output logic               vram_spec,
  output logic [VRAM_AW-1:0] vram_addr,
  output logic [DW-1:0]      vram_wdata,
  input  logic               vram_ack,
  input  logic [DW-1:0]      vram_rdata
);
  logic [PAGE_W-1:0]  page_q;
  logic               off_q;
  logic [DW-1:0]      bank_q;
  logic               hit, tgt_void, tgt_spec;
  logic [VRAM_AW-1:0] tgt_addr;

  vwm_regs #(.DW(DW), .PAGE_W(PAGE_W)) regs_i (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_sel(io_sel), .io_data(io_data),
    .page_q(page_q), .off_q(off_q), .bank_q(bank_q)
  );

  vwm_decode #(.DW(DW), .CPU_AW(CPU_AW), .WIN_AW(WIN_AW), .N_BANKS(N_BANKS),
               .SEL_W(SEL_W), .VRAM_AW(VRAM_AW)) dec_i (
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .page_q(page_q), .off_q(off_q), .bank_q(bank_q),
    .hit(hit), .tgt_void(tgt_void), .tgt_spec(tgt_spec), .tgt_addr(tgt_addr)
  );

  vwm_seq #(.DW(DW), .VRAM_AW(VRAM_AW)) seq_i (
    .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .hit(hit), .tgt_void(tgt_void),
    .tgt_spec(tgt_spec), .tgt_addr(tgt_addr), .vram_ack(vram_ack),
    .vram_rdata(vram_rdata), .cpu_wait(cpu_wait), .mem_rdata(mem_rdata),
    .vram_req(vram_req), .vram_we(vram_we), .vram_spec(vram_spec),
    .vram_addr(vram_addr), .vram_wdata(vram_wdata)
  );

  assign mem_claim = hit;
endmodule

// File: rtl/vwm_checker.sv
module vwm_checker #(
  parameter int DW      = 8,
  parameter int WIN_AW  = 14,
  parameter int N_BANKS = 32,
  parameter int VRAM_AW = 19
) (
  input logic               clk,
  input logic               rst,
  input logic               mem_claim,
  input logic               cpu_wait,
  input logic               vram_req,
  input logic               vram_we,
  input logic               vram_spec,
  input logic [VRAM_AW-1:0] vram_addr,
  input logic               vram_ack,
  input logic [DW-1:0]      bank_q
);
  localparam logic [DW-1:0] SPEC_BANK = DW'(N_BANKS);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    vram_req && !vram_ack |=> vram_req && $stable(vram_addr) && $stable(vram_we));
  // R9
  single_req_chk: assert property (@(posedge clk) disable iff (rst)
    vram_req && vram_ack |=> !vram_req);
  // R7
  wait_cover_chk: assert property (@(posedge clk) disable iff (rst)
    vram_req |-> cpu_wait);
  // R3
  no_claim_no_wait_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_claim |-> !cpu_wait);
  // R5
  spec_addr_chk: assert property (@(posedge clk) disable iff (rst)
    vram_req && vram_spec |-> vram_addr[VRAM_AW-1:WIN_AW] == '0);
  // R2
  req_after_claim_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vram_req) |-> $past(mem_claim));
  // R6
  no_void_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vram_req) |-> $past(bank_q) <= SPEC_BANK);
endmodule

bind vram_window_mapper vwm_checker #(
  .DW(DW), .WIN_AW(WIN_AW), .N_BANKS(N_BANKS), .VRAM_AW(VRAM_AW)
) chk_i (
  .clk(clk), .rst(rst), .mem_claim(mem_claim), .cpu_wait(cpu_wait),
  .vram_req(vram_req), .vram_we(vram_we), .vram_spec(vram_spec),
  .vram_addr(vram_addr), .vram_ack(vram_ack), .bank_q(bank_q)
);

// File: tb/vram_window_mapper_tb.sv
module vram_window_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_wr = 1'b0, io_sel = 1'b0;
  logic [7:0]  io_data = '0;
  logic        mem_rd = 1'b0, mem_wr = 1'b0;
  logic [15:0] mem_addr = '0;
  logic [7:0]  mem_wdata = '0;
  logic [7:0]  mem_rdata;
  logic        mem_claim, cpu_wait;
  logic        vram_req, vram_we, vram_spec;
  logic [18:0] vram_addr;
  logic [7:0]  vram_wdata;
  logic        vram_ack = 1'b0;
  logic [7:0]  vram_rdata = '0;

  always #2.5 clk = ~clk;

  vram_window_mapper dut_i (.*);

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // responder
  int          req_cnt = 0;
  int          lat = 0;
  logic [18:0] l_addr;
  logic        l_spec, l_we;
  logic [7:0]  l_wdata;

  function automatic logic [7:0] fdata(logic [18:0] a, logic s);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ (s ? 8'hA5 : 8'h00);
  endfunction

  always @(posedge clk) begin
    vram_ack <= 1'b0;
    if (vram_req && !vram_ack) begin
      if (lat == 0) begin
        vram_ack   <= 1'b1;
        vram_rdata <= fdata(vram_addr, vram_spec);
        l_addr  <= vram_addr; l_spec <= vram_spec;
        l_we    <= vram_we;   l_wdata <= vram_wdata;
        req_cnt <= req_cnt + 1;
        lat     <= int'($urandom % 3);
      end else lat <= lat - 1;
    end
  end

  task automatic chk(bit ok, string r, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  // model state
  logic [1:0] m_page = 0;
  logic       m_off = 1;
  logic [7:0] m_bank = 0;

  task automatic io_write(bit sel, logic [7:0] d);
    @(negedge clk);
    io_wr = 1; io_sel = sel; io_data = d;
    @(negedge clk);
    io_wr = 0;
    if (!sel) begin m_page = d[1:0]; m_off = d[7]; end
    else m_bank = d;
  endtask

  task automatic access(bit rd, logic [15:0] a, logic [7:0] wd);
    int c0, guard;
    bit claimed, w0, exp_claim, is_void;
    logic [18:0] e_addr;
    logic e_spec;
    @(negedge clk);
    c0 = req_cnt;
    mem_addr = a; mem_wdata = wd; mem_rd = rd; mem_wr = !rd;
    #1;
    claimed = mem_claim; w0 = cpu_wait;
    guard = 0;
    while (cpu_wait && guard < 50) begin @(negedge clk); guard++; end
    #1;
    exp_claim = !m_off && (a[15:14] == m_page);
    is_void   = m_bank > 8'd32;
    e_spec    = (m_bank == 8'd32);
    e_addr    = (m_bank < 8'd32) ? {m_bank[4:0], a[13:0]} : {5'b0, a[13:0]};
    // R2 / R3: claim decode
    chk(claimed == exp_claim, m_off ? "R3" : "R2", claimed, exp_claim);
    if (!exp_claim) begin
      chk(req_cnt == c0 && !w0, "R3", req_cnt - c0, 0);
    end else if (is_void) begin
      chk(req_cnt == c0, "R6", req_cnt - c0, 0);
      if (rd) chk(mem_rdata == 8'hFF, "R6", mem_rdata, 8'hFF);
    end else begin
      chk(w0 && guard < 50, "R7", w0, 1);
      chk(req_cnt == c0 + 1, "R9", req_cnt - c0, 1);
      chk(l_addr == e_addr, e_spec ? "R5" : "R4", l_addr, e_addr);
      chk(l_spec == e_spec, e_spec ? "R5" : "R4", l_spec, e_spec);
      chk(l_we == !rd, "R9", l_we, !rd);
      if (rd) chk(mem_rdata == fdata(e_addr, e_spec), "R8", mem_rdata, fdata(e_addr, e_spec));
      else    chk(l_wdata == wd, "R9", l_wdata, wd);
    end
    mem_rd = 0; mem_wr = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state, window off, bank 0
    chk(!mem_claim && !cpu_wait && !vram_req, "R1", mem_claim, 0);
    access(1, 16'h0123, 8'h00);
    io_write(0, 8'h00);
    access(1, 16'h0123, 8'h00);                      // R1 bank 0 -> offset
    chk(l_addr == 19'h00123, "R1", l_addr, 19'h00123);
    // R4 top of normal range
    io_write(1, 8'd31);
    access(1, 16'h3FFF, 8'h00);
    chk(l_addr == 19'h7FFFF, "R4", l_addr, 19'h7FFFF);
    access(0, 16'h2000, 8'h3C);
    // R2 other pages
    io_write(0, 8'h03);
    access(1, 16'h0010, 8'h00);
    access(0, 16'hC010, 8'h77);
    // R5 special bank
    io_write(1, 8'd32);
    access(1, 16'hC2AB, 8'h00);
    access(0, 16'hFFFF, 8'h99);
    // R6 unmapped banks
    io_write(1, 8'd33);
    access(0, 16'hC000, 8'h11);
    access(1, 16'hC000, 8'h00);
    io_write(1, 8'hFF);
    access(1, 16'hD234, 8'h00);
    // R3 off flag
    io_write(0, 8'h83);
    access(0, 16'hC000, 8'h55);
    access(1, 16'hC000, 8'h00);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int k = int'($urandom % 8);
      if (k == 0) io_write(0, {($urandom % 5 == 0), 5'b0, 2'($urandom)});
      else if (k == 1) io_write(1, ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 34));
      else access(bit'($urandom), {m_page ^ 2'(($urandom % 4 == 0) ? $urandom : 0), 14'($urandom)}, 8'($urandom));
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule